// File: doc/BRIEF.md
# Over-Temperature Supervisor with Short-Circuit Foldback

This block watches a digitised die temperature and decides when the regulator pass devices must be switched off. It works from a signed temperature code in whole degrees Celsius, presented with a one-cycle sample strobe. It also takes one flag per regulator that reports an output below its short-circuit level. The decision has hysteresis. Once the pass devices are off, they come back on only when the die has cooled well below the trip point.

Two threshold pairs are available. In normal operation the block trips above 170 C and releases at or below 130 C. When every regulator output reports a short, and that condition has held for a qualifying run of samples, the block enters foldback. In foldback it trips above 110 C and releases at or below 80 C, which keeps the package cooler while a hard short persists. Foldback is left only when the short has cleared and the pass devices are on.

Top module: `thermal_foldback_guard`

## Requirements
- R1: After reset, and whenever reset is applied, `pass_off` is 0 and `fold_active` is 0, and the short run count is cleared.
- R2: When foldback is inactive, a sample with `temp_code` strictly greater than 170 sets `pass_off` at the clock edge that takes the sample. A sample of exactly 170 does not set it.
- R3: When foldback is inactive and `pass_off` is 1, a sample with `temp_code` at or below 130 clears `pass_off`. A sample of 131 leaves it set.
- R4: `fold_active` is set at the edge that takes the 16th consecutive sample on which every bit of `out_short` is 1. Fifteen such samples leave it at 0.
- R5: A sample on which any bit of `out_short` is 0 restarts the run count. A sample on which only some regulators report a short does not count toward the run.
- R6: While `fold_active` is 1, a sample above 110 sets `pass_off`. A sample of exactly 110 does not set it.
- R7: While `fold_active` is 1 and `pass_off` is 1, a sample at or below 80 clears `pass_off`. A sample of 81 leaves it set.
- R8: `fold_active` clears on a sample where not every bit of `out_short` is 1 and `pass_off` was 0 before that sample. While `pass_off` is 1, `fold_active` holds.
- R9: Clock cycles with `sample_valid` low change neither output, whatever `temp_code` and `out_short` carry.
- R10: The thresholds applied to a sample are chosen by the value `fold_active` held before that sample. A hot sample that completes the qualifying run is therefore compared against the normal pair.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sample_valid | input | 1 | One-cycle strobe marking a new temperature and short sample |
| temp_code | input | TEMP_W (9) | Signed die temperature, degrees C |
| out_short | input | N_REG (2) | Per-regulator flag, 1 = output below the short level |
| pass_off | output | 1 | 1 = pass elements forced off |
| fold_active | output | 1 | 1 = lowered foldback thresholds in force |

## Verification
The hardest state to reach from the ports is foldback held while the pass devices are off and the shorts have already gone. Reaching it takes a full 16-sample qualifying run, then a hot sample, then a sample that removes the shorts while the die is still above the foldback release. From there the stimulus steps the temperature down to the release point to show that foldback outlasts the shutdown by exactly one sample. A second directed path completes the qualifying run with a sample that is already hot. This shows that the hot sample is judged against the normal pair and that the trip comes one sample later.

// File: rtl/thermal_foldback_guard.sv
module thermal_foldback_guard #(
  parameter int TEMP_W    = 9,
  parameter int N_REG     = 2,
  parameter int TRIP_NORM = 170,
  parameter int REL_NORM  = 130,
  parameter int TRIP_FOLD = 110,
  parameter int REL_FOLD  = 80,
  parameter int DEB_LEN   = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     sample_valid,
  input  logic signed [TEMP_W-1:0] temp_code,
  input  logic [N_REG-1:0]         out_short,
  output logic                     pass_off,
  output logic                     fold_active
);
  localparam int CNT_W = $clog2(DEB_LEN + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(DEB_LEN);
  localparam logic [CNT_W-1:0] CNT_PRE = CNT_W'(DEB_LEN - 1);
  localparam logic signed [TEMP_W-1:0] TRIP_N = TEMP_W'(TRIP_NORM);
  localparam logic signed [TEMP_W-1:0] REL_N  = TEMP_W'(REL_NORM);
  localparam logic signed [TEMP_W-1:0] TRIP_F = TEMP_W'(TRIP_FOLD);
  localparam logic signed [TEMP_W-1:0] REL_F  = TEMP_W'(REL_FOLD);

  logic [CNT_W-1:0] deb_cnt, deb_nxt;
  logic all_short, qualified, over_trip, at_release;
  logic signed [TEMP_W-1:0] trip_lvl, rel_lvl;

  assign all_short  = &out_short;
  assign deb_nxt    = !all_short ? '0 : (deb_cnt == CNT_MAX) ? deb_cnt : deb_cnt + 1'b1;
  assign qualified  = (deb_nxt == CNT_MAX);
  assign trip_lvl   = fold_active ? TRIP_F : TRIP_N;
  assign rel_lvl    = fold_active ? REL_F  : REL_N;
  assign over_trip  = temp_code >  trip_lvl;
  assign at_release = temp_code <= rel_lvl;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      deb_cnt     <= '0;
      pass_off    <= 1'b0;
      fold_active <= 1'b0;
    end else if (sample_valid) begin
      deb_cnt <= deb_nxt;
      if (!pass_off && over_trip)
        pass_off <= 1'b1;
      else if (pass_off && at_release)
        pass_off <= 1'b0;
      if (!fold_active && qualified)
        fold_active <= 1'b1;
      else if (fold_active && !all_short && !pass_off)
        fold_active <= 1'b0;
    end
  end

  p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !sample_valid |=> $stable(pass_off) && $stable(fold_active));

  p_trip_normal_r2: assert property (@(posedge clk) disable iff (!rst_n)
    sample_valid && !fold_active && !pass_off && temp_code > TRIP_N |=> pass_off);

  p_fold_entry_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fold_active) |-> $past(deb_cnt) == CNT_PRE && $past(sample_valid && all_short));

  p_release_fold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    sample_valid && fold_active && pass_off && temp_code <= REL_F |=> !pass_off);

  p_fold_kept_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
    fold_active && pass_off |=> fold_active);
endmodule

// File: tb/thermal_foldback_guard_tb.sv
module thermal_foldback_guard_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sample_valid = 1'b0;
  logic signed [8:0] temp_code = '0;
  logic [1:0] out_short = '0;
  logic pass_off, fold_active;
  int n_tests = 0;
  int n_fail = 0;
  bit done = 0;

  always #2 clk = ~clk;

  thermal_foldback_guard u_dut (
    .clk(clk), .rst_n(rst_n), .sample_valid(sample_valid), .temp_code(temp_code),
    .out_short(out_short), .pass_off(pass_off), .fold_active(fold_active));

  task automatic check(input logic got, input logic exp, input string what);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0b expected %0b", what, got, exp);
    end
  endtask

  task automatic sample(input int t, input logic [1:0] s);
    @(negedge clk);
    temp_code = 9'(t);
    out_short = s;
    sample_valid = 1'b1;
    @(negedge clk);
    sample_valid = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_reset();
    do_reset();
    check(pass_off, 1'b0, "R1 reset pass_off");
    check(fold_active, 1'b0, "R1 reset fold_active");
  endtask

  task automatic t_normal();
    sample(170, 2'b00); check(pass_off, 1'b0, "R2 170 no trip");
    sample(171, 2'b00); check(pass_off, 1'b1, "R2 171 trips");
    sample(131, 2'b00); check(pass_off, 1'b1, "R3 131 holds");
    sample(130, 2'b00); check(pass_off, 1'b0, "R3 130 releases");
  endtask

  task automatic t_idle();
    sample(200, 2'b00); check(pass_off, 1'b1, "R9 setup trip");
    @(negedge clk);
    temp_code = 9'sd0;
    out_short = 2'b11;
    repeat (20) @(negedge clk);
    check(pass_off, 1'b1, "R9 idle pass_off");
    check(fold_active, 1'b0, "R9 idle fold_active");
    sample(100, 2'b00); check(pass_off, 1'b0, "R9 release after idle");
  endtask

  task automatic t_debounce();
    for (int i = 0; i < 15; i++) sample(25, 2'b11);
    check(fold_active, 1'b0, "R4 fifteen samples");
    sample(25, 2'b01); check(fold_active, 1'b0, "R5 partial short");
    for (int i = 0; i < 15; i++) sample(25, 2'b11);
    check(fold_active, 1'b0, "R5 run restarted");
    sample(25, 2'b11); check(fold_active, 1'b1, "R4 sixteenth sample");
  endtask

  task automatic t_fold_levels();
    sample(110, 2'b11); check(pass_off, 1'b0, "R6 110 no trip");
    sample(111, 2'b11); check(pass_off, 1'b1, "R6 111 trips");
    sample(81, 2'b11);  check(pass_off, 1'b1, "R7 81 holds");
    sample(80, 2'b11);  check(pass_off, 1'b0, "R7 80 releases");
    check(fold_active, 1'b1, "R7 fold kept");
  endtask

  task automatic t_fold_exit();
    sample(150, 2'b11); check(pass_off, 1'b1, "R8 setup trip");
    sample(100, 2'b00); check(fold_active, 1'b1, "R8 held while off");
    check(pass_off, 1'b1, "R8 still off at 100");
    sample(80, 2'b00);  check(pass_off, 1'b0, "R8 release at 80");
    check(fold_active, 1'b1, "R8 fold outlasts shutdown");
    sample(90, 2'b00);  check(fold_active, 1'b0, "R8 fold exits");
    sample(150, 2'b00); check(pass_off, 1'b0, "R10 normal pair back");
  endtask

  task automatic t_entry_hot();
    for (int i = 0; i < 15; i++) sample(25, 2'b11);
    sample(120, 2'b11);
    check(fold_active, 1'b1, "R10 entry on hot sample");
    check(pass_off, 1'b0, "R10 hot sample judged on normal pair");
    sample(120, 2'b11); check(pass_off, 1'b1, "R6 trips next sample");
    sample(70, 2'b00);  check(pass_off, 1'b0, "R7 release at 70");
    check(fold_active, 1'b1, "R8 fold held on release sample");
    sample(70, 2'b00);  check(fold_active, 1'b0, "R8 fold exits after");
  endtask

  task automatic t_reset_mid();
    for (int i = 0; i < 16; i++) sample(25, 2'b11);
    sample(200, 2'b11);
    check(pass_off, 1'b1, "R1 setup off");
    do_reset();
    check(pass_off, 1'b0, "R1 mid reset pass_off");
    check(fold_active, 1'b0, "R1 mid reset fold_active");
    for (int i = 0; i < 15; i++) sample(25, 2'b11);
    check(fold_active, 1'b0, "R1 run count cleared");
  endtask

  initial begin
    t_reset();
    t_normal();
    t_idle();
    t_debounce();
    t_fold_levels();
    t_fold_exit();
    t_entry_hot();
    t_reset_mid();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule